// File: doc/BRIEF.md
# AES IV and Counter Register Unit

This block holds the 128-bit initialization vector and counter state that an AES engine consumes. Software sees the vector as four 32-bit read/write words on a register bus and loads a starting value before an operation. During the operation the engine signals each new data block with a one-cycle start pulse. The unit then either advances a counter field inside the vector, or, in the chaining modes, takes a 128-bit result vector that the engine presents with a capture pulse.

The counting rule depends on the selected mode. The counter is a big-endian byte string stored in little-endian words, so the last byte of the vector (bits [127:120]) is its least significant byte. CTR counts over the whole vector. GCM counts over the last four bytes. CCM counts over the last L+1 bytes. After a load, the first block of an operation uses the loaded value unchanged. CBC and CBC-MAC do not count: they keep the chaining value or tag that the engine hands back. After the operation, software reads the latest value back through the same words.

Top module: `aes_iv_unit`

## Requirements
- R1: After reset all four words read as zero.
- R2: Word select 0 reads and writes IV bits [31:0], select 1 bits [63:32], select 2 bits [95:64] and select 3 bits [127:96]. Within the vector, byte k is bits [8k+7:8k].
- R3: A register write while `eng_busy` is high leaves the vector unchanged.
- R4: In the counting modes (mode 1 CTR, 2 GCM, 3 CCM), the first `blk_start` after reset or after a software write leaves the vector unchanged.
- R5: In CTR mode, each later `blk_start` adds one to the vector read as a 128-bit big-endian number whose least significant byte is byte 15. The count wraps from all ones to zero.
- R6: In GCM mode, each later `blk_start` adds one to the 32-bit big-endian counter in bytes 12..15, so word 3 goes from 0x01000000 to 0x02000000. The counter wraps from 0xFFFFFFFF to zero and bits [95:0] stay unchanged.
- R7: In CCM mode, with `ccm_l` = L, each later `blk_start` adds one to the big-endian counter in bytes 15-L..15. The counter wraps modulo 2^(8(L+1)) and all other bytes stay unchanged.
- R8: In mode 0 (CBC) and mode 4 (CBC-MAC), `eng_capture` loads `eng_result` into the vector, and `blk_start` leaves the vector unchanged.
- R9: In the counting modes `eng_capture` leaves the vector unchanged.
- R10: A software write to any word re-arms the first-use rule, so the next `blk_start` uses the value unchanged and the one after it increments.
- R11: A software write accepted in the same cycle as `blk_start` or `eng_capture` takes precedence, and that engine event is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Word select (0 = bits [31:0] … 3 = bits [127:96]) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| mode | input | 3 | 0 CBC, 1 CTR, 2 GCM, 3 CCM, 4 CBC-MAC |
| ccm_l | input | 3 | CCM L value; counter is L+1 bytes |
| eng_busy | input | 1 | Engine operation in progress; blocks writes |
| blk_start | input | 1 | One-cycle pulse per data block |
| eng_capture | input | 1 | One-cycle pulse: take `eng_result` |
| eng_result | input | 128 | Chaining value or tag from the engine |

## Verification
Writes, counter steps and captures land on the clock edge that samples them, and read data is a combinational view of the stored vector, so every result can be read one edge after its stimulus. The bench drives stimulus on the falling edge, lets one rising edge pass and reads the words at the next falling edge. Each pulse therefore has exactly one edge to act on, and the expected value follows from the count of pulses since the last write. Same-cycle collisions between a write and an engine event are set up within a single falling-edge slot, so they meet at the same rising edge.

// File: rtl/aes_iv_pkg.sv
// Package: shared mode encoding for the IV/counter unit.
// Assumes the mode field is 3 bits wide; unused codes behave as non-counting.
package aes_iv_pkg;
    typedef enum logic [2:0] {
        MODE_CBC    = 3'd0,
        MODE_CTR    = 3'd1,
        MODE_GCM    = 3'd2,
        MODE_CCM    = 3'd3,
        MODE_CBCMAC = 3'd4
    } aes_mode_e;

    // True for the modes that advance a counter field on each block.
    function automatic logic mode_counts(aes_mode_e m);
        return (m == MODE_CTR) || (m == MODE_GCM) || (m == MODE_CCM);
    endfunction
endpackage

// File: rtl/aes_iv_ctr_step.sv
// Module: aes_iv_ctr_step
// Computes the incremented vector for the counting modes. The counter is a
// big-endian byte string: byte NB-1 is least significant. Only the bytes of the
// mode's counter field change; the sum wraps within that field.
// Assumes IV_W is a multiple of 8 and at least 40 bits.
module aes_iv_ctr_step
    import aes_iv_pkg::*;
#(
    parameter int IV_W          = 128,
    parameter int GCM_CTR_BYTES = 4
) (
    input  logic [IV_W-1:0] cur,
    input  aes_mode_e       mode,
    input  logic [2:0]      ccm_l,
    output logic [IV_W-1:0] nxt
);
    localparam int NB = IV_W / 8;
    localparam int CW = $clog2(NB + 1);

    logic [IV_W-1:0] be_val;
    logic [IV_W-1:0] be_inc;
    logic [IV_W-1:0] be_nxt;
    logic [IV_W-1:0] fmask;
    logic [CW-1:0]   nbytes;

    // Reverse byte order so the counter becomes an ordinary binary number.
    generate
        for (genvar k = 0; k < NB; k++) begin : g_swap
            assign be_val[8*(NB-1-k) +: 8] = cur[8*k +: 8];
            assign nxt[8*k +: 8]           = be_nxt[8*(NB-1-k) +: 8];
        end
    endgenerate

    // Select the counter width in bytes from the mode.
    always_comb begin
        case (mode)
            MODE_CTR: nbytes = CW'(NB);
            MODE_GCM: nbytes = CW'(GCM_CTR_BYTES);
            MODE_CCM: nbytes = CW'(ccm_l) + CW'(1);
            default:  nbytes = '0;
        endcase
    end

    // Build the mask of the low-order bytes that form the counter field.
    always_comb begin
        for (int k = 0; k < NB; k++) begin
            fmask[8*k +: 8] = (CW'(k) < nbytes) ? 8'hFF : 8'h00;
        end
    end

    // Add one and keep only the counter field of the sum.
    assign be_inc = be_val + IV_W'(1);
    assign be_nxt = (be_val & ~fmask) | (be_inc & fmask);
endmodule

// File: rtl/aes_iv_store.sv
// Module: aes_iv_store
// Holds the IV vector and the first-use flag. Applies, in priority order:
// accepted software word write, counter step, engine capture.
// Assumes engine pulses last one cycle.
module aes_iv_store #(
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 4,
    localparam int IV_W   = WORD_W * N_WORDS,
    localparam int SEL_W  = $clog2(N_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              eng_busy,
    input  logic              count_mode,
    input  logic              gcm_mode,
    input  logic              blk_start,
    input  logic              capture,
    input  logic [IV_W-1:0]   step_val,
    input  logic [IV_W-1:0]   result,
    output logic [IV_W-1:0]   iv
);
    localparam int LOW_W = IV_W - 32;

    logic sw_wr;
    logic used;

    // Software writes are accepted only while the engine is idle.
    assign sw_wr = reg_wr && !eng_busy;

    // Update the vector and the first-use flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iv   <= '0;
            used <= 1'b0;
        end else if (sw_wr) begin
            for (int w = 0; w < N_WORDS; w++) begin
                if (SEL_W'(w) == reg_sel) iv[w*WORD_W +: WORD_W] <= reg_wdata;
            end
            used <= 1'b0;
        end else if (count_mode && blk_start) begin
            if (used) iv <= step_val;
            used <= 1'b1;
        end else if (!count_mode && capture) begin
            iv <= result;
        end
    end

    // R3
    write_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && eng_busy && !blk_start && !capture) |=> $stable(iv));

    // R4
    first_use_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_mode && blk_start && !used && !sw_wr) |=> $stable(iv));

    // R8
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_mode && capture && !sw_wr) |=> (iv == $past(result)));

    // R6
    gcm_low_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gcm_mode && blk_start && !sw_wr) |=> (iv[LOW_W-1:0] == $past(iv[LOW_W-1:0])));

    // R9
    count_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_mode && capture && !blk_start && !sw_wr) |=> $stable(iv));
endmodule

// File: rtl/aes_iv_rdmux.sv
// Module: aes_iv_rdmux
// Presents the selected word of the vector; word 0 is the lowest bits.
// Assumes N_WORDS is a power of two.
module aes_iv_rdmux #(
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 4,
    localparam int IV_W   = WORD_W * N_WORDS,
    localparam int SEL_W  = $clog2(N_WORDS)
) (
    input  logic [IV_W-1:0]   iv,
    input  logic [SEL_W-1:0]  sel,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] words [N_WORDS];

    // Slice the vector into words.
    generate
        for (genvar w = 0; w < N_WORDS; w++) begin : g_word
            assign words[w] = iv[w*WORD_W +: WORD_W];
        end
    endgenerate

    // Return the addressed word.
    assign rdata = words[sel];
endmodule

// File: rtl/aes_iv_unit.sv
// Module: aes_iv_unit (top)
// IV and counter register unit for an AES engine: four register words, a
// mode-dependent counter step and a result capture path.
// Assumes single-cycle engine pulses and a combinational register read.
module aes_iv_unit
    import aes_iv_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 4,
    localparam int IV_W   = WORD_W * N_WORDS,
    localparam int SEL_W  = $clog2(N_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [2:0]        mode,
    input  logic [2:0]        ccm_l,
    input  logic              eng_busy,
    input  logic              blk_start,
    input  logic              eng_capture,
    input  logic [IV_W-1:0]   eng_result
);
    aes_mode_e       mode_e;
    logic            count_mode;
    logic            gcm_mode;
    logic [IV_W-1:0] iv;
    logic [IV_W-1:0] step_val;

    // Decode the mode field.
    assign mode_e     = aes_mode_e'(mode);
    assign count_mode = mode_counts(mode_e);
    assign gcm_mode   = (mode_e == MODE_GCM);

    aes_iv_ctr_step #(.IV_W(IV_W), .GCM_CTR_BYTES(4)) u_step (
        .cur   (iv),
        .mode  (mode_e),
        .ccm_l (ccm_l),
        .nxt   (step_val)
    );

    aes_iv_store #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .eng_busy   (eng_busy),
        .count_mode (count_mode),
        .gcm_mode   (gcm_mode),
        .blk_start  (blk_start),
        .capture    (eng_capture),
        .step_val   (step_val),
        .result     (eng_result),
        .iv         (iv)
    );

    aes_iv_rdmux #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_rd (
        .iv    (iv),
        .sel   (reg_sel),
        .rdata (reg_rdata)
    );
endmodule

// File: tb/aes_iv_unit_test.sv
`timescale 1ns/1ps
module aes_iv_unit_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [1:0]   reg_sel = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [2:0]   mode = '0;
    logic [2:0]   ccm_l = '0;
    logic         eng_busy = 1'b0;
    logic         blk_start = 1'b0;
    logic         eng_capture = 1'b0;
    logic [127:0] eng_result = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    aes_iv_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mode(mode),
        .ccm_l(ccm_l), .eng_busy(eng_busy), .blk_start(blk_start),
        .eng_capture(eng_capture), .eng_result(eng_result)
    );

    // Vector format: {mode[2:0], L[2:0], steps after first use[3:0], init[127:0], expected[127:0]}
    localparam int NV = 9;
    localparam logic [265:0] VEC [NV] = '{
        {3'd1, 3'd0, 4'd1, 128'hFF000000_00000000_00000000_00000000, 128'h00010000_00000000_00000000_00000000},
        {3'd1, 3'd0, 4'd1, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 128'h00000000_00000000_00000000_00000000},
        {3'd1, 3'd0, 4'd1, 128'hFFFFFFFF_00000000_00000000_00000000, 128'h00000000_01000000_00000000_00000000},
        {3'd1, 3'd0, 4'd0, 128'h12345678_9ABCDEF0_0F0F0F0F_F0F0F0F0, 128'h12345678_9ABCDEF0_0F0F0F0F_F0F0F0F0},
        {3'd2, 3'd0, 4'd1, 128'h01000000_AAAAAAAA_AAAAAAAA_AAAAAAAA, 128'h02000000_AAAAAAAA_AAAAAAAA_AAAAAAAA},
        {3'd2, 3'd0, 4'd1, 128'hFFFFFFFF_11111111_11111111_11111111, 128'h00000000_11111111_11111111_11111111},
        {3'd3, 3'd1, 4'd1, 128'hFFFF5A00_22222222_22222222_22222201, 128'h00005A00_22222222_22222222_22222201},
        {3'd3, 3'd3, 4'd3, 128'h00000000_33333333_33333333_33333303, 128'h03000000_33333333_33333333_33333303},
        {3'd3, 3'd0, 4'd1, 128'hFF123456_44444444_44444444_44444400, 128'h00123456_44444444_44444444_44444400}
    };

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %032h expected %032h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic write_iv(input logic [127:0] v);
        for (int i = 0; i < 4; i++) write_word(2'(i), v[32*i +: 32]);
    endtask

    task automatic read_iv(output logic [127:0] v);
        for (int i = 0; i < 4; i++) begin
            reg_sel = 2'(i);
            #0.5;
            v[32*i +: 32] = reg_rdata;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); blk_start = 1'b1;
        @(negedge clk); blk_start = 1'b0;
    endtask

    task automatic pulse_capture(input logic [127:0] r);
        @(negedge clk); eng_capture = 1'b1; eng_result = r;
        @(negedge clk); eng_capture = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] got;
        logic [127:0] exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        read_iv(got);
        check(got == '0, "R1", got, '0);

        // R2: word placement
        write_iv(128'hDDDDDDDD_CCCCCCCC_BBBBBBBB_AAAAAAAA);
        for (int i = 0; i < 4; i++) begin
            reg_sel = 2'(i); #0.5;
            exp = 128'(32'hAAAAAAAA + 32'h11111111 * i);
            check(reg_rdata == exp[31:0], "R2", 128'(reg_rdata), exp);
        end

        // Vector table: R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            mode  = VEC[v][265:263];
            ccm_l = VEC[v][262:260];
            write_iv(VEC[v][255:128]);
            for (int s = 0; s <= int'(VEC[v][259:256]); s++) pulse_start();
            read_iv(got);
            check(got == VEC[v][127:0], "R4/R5/R6/R7 vector", got, VEC[v][127:0]);
        end

        // R3: write while busy ignored
        mode = 3'd1;
        write_iv(128'h0);
        @(negedge clk); eng_busy = 1'b1;
        write_word(2'd2, 32'hDEADBEEF);
        @(negedge clk); eng_busy = 1'b0;
        read_iv(got);
        check(got == '0, "R3", got, '0);

        // R8: CBC capture and start ignored
        mode = 3'd0;
        write_iv(128'h0);
        pulse_capture(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
        read_iv(got);
        check(got == 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, "R8 CBC capture", got, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
        pulse_start(); pulse_start();
        read_iv(got);
        check(got == 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, "R8 CBC start", got, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
        mode = 3'd4;
        write_iv(128'h0);
        pulse_capture(128'hCAFEF00D_00000000_11112222_33334444);
        read_iv(got);
        check(got == 128'hCAFEF00D_00000000_11112222_33334444, "R8 CBC-MAC tag", got, 128'hCAFEF00D_00000000_11112222_33334444);

        // R9: capture ignored in CTR
        mode = 3'd1;
        write_iv(128'h05000000_00000000_00000000_00000000);
        pulse_capture({128{1'b1}});
        read_iv(got);
        check(got == 128'h05000000_00000000_00000000_00000000, "R9", got, 128'h05000000_00000000_00000000_00000000);

        // R10: write re-arms first use
        write_iv(128'h0);
        pulse_start(); pulse_start();
        write_word(2'd1, 32'h00000009);
        pulse_start();
        read_iv(got);
        exp = 128'h01000000_00000000_00000009_00000000;
        check(got == exp, "R10 first after write", got, exp);
        pulse_start();
        read_iv(got);
        exp = 128'h02000000_00000000_00000009_00000000;
        check(got == exp, "R10 step after write", got, exp);

        // R11: write beats same-cycle start
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd3; reg_wdata = 32'h77000000; blk_start = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; blk_start = 1'b0;
        read_iv(got);
        exp = 128'h77000000_00000000_00000009_00000000;
        check(got == exp, "R11 write wins", got, exp);
        pulse_start();
        read_iv(got);
        check(got == exp, "R11 start dropped, first use", got, exp);
        pulse_start();
        read_iv(got);
        exp = 128'h78000000_00000000_00000009_00000000;
        check(got == exp, "R11 next step", got, exp);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule